// File: doc/BRIEF.md
# Hamming (12,8) Single-Error-Correcting Codec

This block protects a byte with four check bits. On the encode side it takes an 8-bit value and forms a 12-bit code word. Positions in the code word are counted from 1, and position 1 is the most significant bit of the vector. The check bits sit at the positions that are powers of two. Each check bit makes its group of covered positions even.

On the decode side the block takes a 12-bit word that may be damaged and recomputes the four checks. The failing checks form a syndrome that points at the damaged position. The block inverts that position and extracts the byte. If the syndrome names a position beyond the end of the word, the block marks the word as uncorrectable and passes it through unchanged.

The encode and decode paths are independent. Each path is one register stage, with a valid strobe that follows its input strobe by one clock. A path has no state sequence: its only state is the registered result and its valid bit. A result register loads only when its input strobe is high, so it holds its value between strobes.

Top module: `hamming_codec`

## Requirements
- R1: Data bits fill positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order, from the data MSB down to its LSB. Position p is code-vector bit 12-p. The check bit at position 2^j is chosen so that the positions whose index has bit j set hold an even number of ones. For example, data 0x9A encodes to 0x72A.
- R2: enc_valid_o is high exactly one cycle after enc_valid_i. enc_code_o loads only on a cycle with enc_valid_i high, and otherwise keeps its value.
- R3: Syndrome bit j is the parity of all received positions whose index has bit j set. The syndrome value therefore equals the sum of the failing check positions; for example, 0x72E gives syndrome 10.
- R4: A syndrome of zero leaves the word unchanged, with dec_corrected_o and dec_uncorr_o both low.
- R5: A syndrome from 1 to 12 inverts that position. dec_corrected_o goes high, and dec_data_o is taken from the corrected word. This applies to check positions as well as data positions.
- R6: A syndrome from 13 to 15 raises dec_uncorr_o and leaves dec_corrected_o low. dec_code_o equals the received word, and dec_data_o is taken from it unchanged.
- R7: dec_valid_o is high exactly one cycle after dec_valid_i. The decode outputs load only on a cycle with dec_valid_i high, and otherwise keep their values.
- R8: While rst_n is low, every output is zero.
- R9: Any two-bit error gives a nonzero syndrome, so it is never reported as clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 12 | Encoded word, position 1 at MSB |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_code_i | input | 12 | Received word, position 1 at MSB |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Extracted byte |
| dec_code_o | output | 12 | Corrected (or passed) word |
| dec_syndrome_o | output | 4 | Syndrome of the received word |
| dec_corrected_o | output | 1 | A single position was inverted |
| dec_uncorr_o | output | 1 | Syndrome beyond the last position |

## Verification
The bench flips every one of the twelve positions in several encoded words, so each check position and the last data position are covered. A codec with a mirrored bit order or an off-by-one position map would then correct the wrong bit or extract the wrong byte. Double errors that give syndromes 13, 14 and 15 confirm that the out-of-range case raises the flag and never writes past the word. A double error that lands inside the range confirms that its syndrome is nonzero, even though the correction it leads to is wrong. The bench also changes the inputs while the strobes are low, which exposes registers that load without a strobe.

// File: rtl/hc_pkg.sv
package hc_pkg;

    // Smallest number of check bits r with 2^r >= data + r + 1.
    function automatic int parity_count(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // True for positions 1, 2, 4, 8, ... that carry check bits.
    function automatic bit is_check_pos(input int pos);
        return (pos & (pos - 1)) == 0;
    endfunction

endpackage

// File: rtl/hc_encoder.sv
module hc_encoder #(
    parameter int DATA_W = 8,
    parameter int PAR_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    import hc_pkg::*;

    always_comb begin
        logic [CODE_W-1:0] w;
        logic              p;
        int                k;
        w = '0;
        k = 0;
        // Place data bits, MSB first, into non-check positions.
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!is_check_pos(pos)) begin
                w[CODE_W-pos] = data_i[DATA_W-1-k];
                k++;
            end
        end
        // Each check bit evens out the positions whose index has bit j set.
        for (int j = 0; j < PAR_W; j++) begin
            p = 1'b0;
            for (int pos = 1; pos <= CODE_W; pos++) begin
                if (pos[j] && pos != (1 << j)) p = p ^ w[CODE_W-pos];
            end
            w[CODE_W-(1<<j)] = p;
        end
        code_o = w;
    end

endmodule

// File: rtl/hc_syndrome.sv
module hc_syndrome #(
    parameter int PAR_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [PAR_W-1:0]  syn_o
);

    always_comb begin
        logic [PAR_W-1:0] s;
        s = '0;
        for (int j = 0; j < PAR_W; j++) begin
            for (int pos = 1; pos <= CODE_W; pos++) begin
                if (pos[j]) s[j] = s[j] ^ code_i[CODE_W-pos];
            end
        end
        syn_o = s;
    end

endmodule

// File: rtl/hc_corrector.sv
module hc_corrector #(
    parameter int DATA_W = 8,
    parameter int PAR_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [PAR_W-1:0]  syn_i,
    output logic [CODE_W-1:0] fixed_o,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              unc_o
);
    import hc_pkg::*;

    always_comb begin
        logic [CODE_W-1:0] w;
        int                k;
        w      = code_i;
        corr_o = 1'b0;
        unc_o  = 1'b0;
        if (syn_i != '0) begin
            if (int'(syn_i) <= CODE_W) begin
                w[CODE_W-int'(syn_i)] = ~w[CODE_W-int'(syn_i)];
                corr_o = 1'b1;
            end else begin
                unc_o = 1'b1;
            end
        end
        fixed_o = w;
        data_o  = '0;
        k       = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!is_check_pos(pos)) begin
                data_o[DATA_W-1-k] = w[CODE_W-pos];
                k++;
            end
        end
    end

endmodule

// File: rtl/hamming_codec.sv
module hamming_codec #(
    parameter  int DATA_W = 8,
    localparam int PAR_W  = hc_pkg::parity_count(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CODE_W-1:0] dec_code_o,
    output logic [PAR_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorr_o
);

    logic [CODE_W-1:0] enc_word;
    logic [PAR_W-1:0]  rx_syn;
    logic [CODE_W-1:0] rx_fixed;
    logic [DATA_W-1:0] rx_data;
    logic              rx_corr;
    logic              rx_unc;
    logic [PAR_W-1:0]  enc_chk_syn;

    hc_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_word)
    );

    hc_syndrome #(.PAR_W(PAR_W), .CODE_W(CODE_W)) u_syn (
        .code_i (dec_code_i),
        .syn_o  (rx_syn)
    );

    hc_corrector #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_fix (
        .code_i  (dec_code_i),
        .syn_i   (rx_syn),
        .fixed_o (rx_fixed),
        .data_o  (rx_data),
        .corr_o  (rx_corr),
        .unc_o   (rx_unc)
    );

    // Encode stage register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= enc_word;
        end
    end

    // Decode stage register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid_o     <= 1'b0;
            dec_data_o      <= '0;
            dec_code_o      <= '0;
            dec_syndrome_o  <= '0;
            dec_corrected_o <= 1'b0;
            dec_uncorr_o    <= 1'b0;
        end else begin
            dec_valid_o <= dec_valid_i;
            if (dec_valid_i) begin
                dec_data_o      <= rx_data;
                dec_code_o      <= rx_fixed;
                dec_syndrome_o  <= rx_syn;
                dec_corrected_o <= rx_corr;
                dec_uncorr_o    <= rx_unc;
            end
        end
    end

    // Independent syndrome on the encoder output, used only by a check.
    hc_syndrome #(.PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc_chk (
        .code_i (enc_code_o),
        .syn_o  (enc_chk_syn)
    );

    always_comb begin
        if (rst_n && enc_valid_o)
            a_r1_enc_word_clean: assert (enc_chk_syn == '0);
    end

    a_r2_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    a_r2_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));

    a_r7_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r7_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> $stable(dec_code_o) && $stable(dec_syndrome_o));

    a_r4_clean_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == '0) |-> !dec_corrected_o && !dec_uncorr_o);

    a_r5_one_bit_flipped: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (dec_corrected_o ->
            $countones(dec_code_o ^ $past(dec_code_i)) == 1));

    a_r6_unc_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (!dec_corrected_o -> dec_code_o == $past(dec_code_i)));

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_uncorr_o));

endmodule

// File: tb/hamming_codec_test.sv
`timescale 1ns/1ps
module hamming_codec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [11:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [11:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [11:0] dec_code_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_corrected_o;
    logic        dec_uncorr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hamming_codec uut (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_code_o(dec_code_o), .dec_syndrome_o(dec_syndrome_o),
        .dec_corrected_o(dec_corrected_o), .dec_uncorr_o(dec_uncorr_o)
    );

    localparam int NENC = 5;
    localparam logic [7:0]  ENC_D [NENC] = '{8'h9A, 8'h00, 8'hFF, 8'h01, 8'h80};
    localparam logic [11:0] ENC_C [NENC] = '{12'h72A, 12'h000, 12'hEEF, 12'h111, 12'hE00};

    localparam int NDEC = 11;
    localparam logic [11:0] DV_IN  [NDEC] = '{12'h72A, 12'h72E, 12'hF2A, 12'h72B, 12'h73A,
        12'h000, 12'hFFF, 12'h7BA, 12'h77A, 12'h71A, 12'h5AA};
    localparam logic [11:0] DV_FIX [NDEC] = '{12'h72A, 12'h72A, 12'h72A, 12'h72A, 12'h72A,
        12'h000, 12'hFFE, 12'h7BA, 12'h77A, 12'h71A, 12'h5EA};
    localparam logic [7:0]  DV_DAT [NDEC] = '{8'h9A, 8'h9A, 8'h9A, 8'h9A, 8'h9A,
        8'h00, 8'hFE, 8'hDA, 8'hBA, 8'h8A, 8'h7A};
    localparam logic [3:0]  DV_SYN [NDEC] = '{4'd0, 4'd10, 4'd1, 4'd12, 4'd8,
        4'd0, 4'd12, 4'd13, 4'd14, 4'd15, 4'd6};
    localparam logic        DV_COR [NDEC] = '{0, 1, 1, 1, 1, 0, 1, 0, 0, 0, 1};
    localparam logic        DV_UNC [NDEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_enc(input logic [7:0] d);
        @(negedge clk);
        enc_data_i  = d;
        enc_valid_i = 1'b1;
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    task automatic run_dec(input logic [11:0] c);
        @(negedge clk);
        dec_code_i  = c;
        dec_valid_i = 1'b1;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R8: outputs during reset
        #3;
        chk({enc_valid_o, enc_code_o, dec_valid_o, dec_data_o, dec_code_o,
             dec_syndrome_o, dec_corrected_o, dec_uncorr_o} == '0, "R8 reset outputs",
            int'(dec_code_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: encode table
        for (int i = 0; i < NENC; i++) begin
            run_enc(ENC_D[i]);
            chk(enc_valid_o == 1'b1, "R2 enc valid", int'(enc_valid_o), 1);
            chk(enc_code_o == ENC_C[i], "R1 encode", int'(enc_code_o), int'(ENC_C[i]));
        end
        @(negedge clk);
        chk(enc_valid_o == 1'b0, "R2 enc valid drops", int'(enc_valid_o), 0);

        // R3-R6, R9: decode table
        for (int i = 0; i < NDEC; i++) begin
            run_dec(DV_IN[i]);
            chk(dec_valid_o == 1'b1, "R7 dec valid", int'(dec_valid_o), 1);
            chk(dec_syndrome_o == DV_SYN[i], "R3 syndrome", int'(dec_syndrome_o), int'(DV_SYN[i]));
            chk(dec_code_o == DV_FIX[i], DV_UNC[i] ? "R6 word passed" : "R5 word fixed",
                int'(dec_code_o), int'(DV_FIX[i]));
            chk(dec_data_o == DV_DAT[i], DV_UNC[i] ? "R6 data raw" : "R5 data",
                int'(dec_data_o), int'(DV_DAT[i]));
            chk(dec_corrected_o == DV_COR[i], DV_SYN[i] == 0 ? "R4 corrected flag" : "R5 corrected flag",
                int'(dec_corrected_o), int'(DV_COR[i]));
            chk(dec_uncorr_o == DV_UNC[i], "R6 uncorr flag", int'(dec_uncorr_o), int'(DV_UNC[i]));
            if (i == 10)
                chk(dec_syndrome_o != 0, "R9 double error nonzero", int'(dec_syndrome_o), 6);
        end

        // R5: every single-position error in every table word
        for (int i = 0; i < NENC; i++) begin
            for (int pos = 1; pos <= 12; pos++) begin
                logic [11:0] bad;
                bad = ENC_C[i];
                bad[12-pos] = ~bad[12-pos];
                run_dec(bad);
                chk(dec_syndrome_o == pos[3:0] && dec_corrected_o && !dec_uncorr_o,
                    "R5 sweep syndrome", int'(dec_syndrome_o), pos);
                chk(dec_code_o == ENC_C[i] && dec_data_o == ENC_D[i],
                    "R5 sweep restore", int'(dec_code_o), int'(ENC_C[i]));
            end
        end

        // R2, R7: inputs change with strobes low, outputs hold
        run_enc(8'h9A);
        run_dec(12'h72E);
        @(negedge clk);
        enc_data_i = 8'h55;
        dec_code_i = 12'hABC;
        @(negedge clk);
        @(negedge clk);
        chk(enc_code_o == 12'h72A && !enc_valid_o, "R2 enc hold", int'(enc_code_o), 'h72A);
        chk(dec_code_o == 12'h72A && dec_syndrome_o == 4'd10 && !dec_valid_o,
            "R7 dec hold", int'(dec_code_o), 'h72A);

        // R8: reset mid-run
        #1;
        rst_n = 1'b0;
        #1;
        chk({enc_valid_o, enc_code_o, dec_valid_o, dec_data_o, dec_code_o,
             dec_syndrome_o, dec_corrected_o, dec_uncorr_o} == '0, "R8 reset clears",
            int'(enc_code_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule